// File: doc/BRIEF.md
# Logical-to-Physical Page Translator

This block translates logical page numbers into physical page numbers for a flash-like store that never overwrites in place. It holds a map from each logical page to the physical page currently holding its data, a three-valued condition for every physical page (free, holding live data, or holding superseded data), and a per-page allocation counter. A read returns the physical page mapped to the requested logical page. A write claims a new free physical page, repoints the map at it, and marks the page it replaces as superseded, so repeated rewrites of one logical page walk across the physical pages instead of wearing one down.

A client raises `req_valid` while `req_ready` is high. The request is taken on that clock edge. The block then stays busy until it pulses `resp_valid` for one cycle with a status code and, where one exists, a physical page number. Reads answer on the edge after acceptance. Writes first run an allocation sweep that visits one physical page per cycle. The sweep keeps the free page with the smallest allocation count, and on a tie the lowest index wins.

The control FSM has four states. IDLE accepts a request and goes to DECODE. DECODE answers a read and returns to IDLE, or starts the sweep for a write and goes to SCAN. SCAN waits for the sweep's done pulse. If a page was found it goes to COMMIT; if none was found it answers full and returns to IDLE. COMMIT updates the map and the page conditions, answers, and returns to IDLE.

Top module: `ftl_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0, and every logical page is unmapped.
- R2: A read of a logical page never written returns status 01 (unmapped) with `resp_ppage` = 0.
- R3: A read of a written logical page returns status 00 and the physical page given by that page's latest successful write. `resp_valid` is high in the cycle after the edge that follows the accepting edge. Other logical pages are unaffected.
- R4: A successful write returns status 00 and a physical page different from the one the logical page held before.
- R5: A write allocates the free physical page with the lowest allocation count, lowest index on ties. From reset, successive writes therefore receive pages 0, 1, 2, and so on.
- R6: A physical page, once allocated, is never allocated again. The page a write replaces becomes superseded, and the number of free pages never rises.
- R7: A write when no physical page is free returns status 10 (full) with `resp_ppage` = 0 and leaves the map unchanged.
- R8: `req_ready` is low from the accepting edge until the response. A `req_valid` raised in that window is ignored.
- R9: Each accepted request produces exactly one `resp_valid` pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write (relocate), 0 = read (translate) |
| req_lpage | input | 4 | Logical page number |
| req_ready | output | 1 | Block idle and able to take a request |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_status | output | 2 | 00 ok, 01 unmapped, 10 full |
| resp_ppage | output | 5 | Physical page number, 0 when status is not ok |

## Verification
The bound checker checks the following on every cycle:
- the response strobe is one cycle wide;
- `req_ready` falls after an acceptance;
- error responses carry page zero;
- the sweep never picks a page that is not free, and reports "none found" only when the free set is empty;
- a commit never reuses the old page;
- the free-page count never grows.

Only the bench's scenarios can show the following:
- the actual mapping contents and the exact allocation order;
- the read latency;
- that a full write leaves every map entry intact;
- that a request raised while busy leaves no trace.

// File: rtl/ftl_pkg.sv
package ftl_pkg;

    typedef enum logic [1:0] {
        PG_FREE  = 2'b00,
        PG_VALID = 2'b01,
        PG_STALE = 2'b10
    } pg_cond_e;

    typedef enum logic [1:0] {
        XS_OK       = 2'b00,
        XS_UNMAPPED = 2'b01,
        XS_FULL     = 2'b10
    } xl_status_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_DECODE,
        S_SCAN,
        S_COMMIT
    } ctl_state_e;

endpackage

// File: rtl/ftl_map_table.sv
module ftl_map_table #(
    parameter int LOG_N  = 16,
    parameter int PHYS_N = 32,
    localparam int LOG_W  = $clog2(LOG_N),
    localparam int PHYS_W = $clog2(PHYS_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LOG_W-1:0]  rd_lpage,
    output logic              rd_mapped,
    output logic [PHYS_W-1:0] rd_ppage,
    input  logic              wr_en,
    input  logic [LOG_W-1:0]  wr_lpage,
    input  logic [PHYS_W-1:0] wr_ppage
);

    logic [LOG_N-1:0]  mapped_q;
    logic [PHYS_W-1:0] target_q [LOG_N];

    for (genvar g = 0; g < LOG_N; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mapped_q[g] <= 1'b0;
                target_q[g] <= '0;
            end else if (wr_en && (wr_lpage == LOG_W'(g))) begin
                mapped_q[g] <= 1'b1;
                target_q[g] <= wr_ppage;
            end
        end
    end

    assign rd_mapped = mapped_q[rd_lpage];
    assign rd_ppage  = target_q[rd_lpage];

endmodule

// File: rtl/ftl_page_pool.sv
module ftl_page_pool
    import ftl_pkg::*;
#(
    parameter int PHYS_N = 32,
    parameter int CNT_W  = 8,
    localparam int PHYS_W = $clog2(PHYS_N)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_en,
    input  logic [PHYS_W-1:0]       alloc_idx,
    input  logic                    retire_en,
    input  logic [PHYS_W-1:0]       retire_idx,
    output logic [PHYS_N-1:0]       free_vec,
    output logic [PHYS_N*CNT_W-1:0] cnt_flat
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    pg_cond_e         cond_q [PHYS_N];
    logic [CNT_W-1:0] cnt_q  [PHYS_N];

    for (genvar g = 0; g < PHYS_N; g++) begin : g_page
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cond_q[g] <= PG_FREE;
                cnt_q[g]  <= '0;
            end else if (alloc_en && (alloc_idx == PHYS_W'(g))) begin
                cond_q[g] <= PG_VALID;
                if (cnt_q[g] != CNT_MAX) begin
                    cnt_q[g] <= cnt_q[g] + 1'b1;
                end
            end else if (retire_en && (retire_idx == PHYS_W'(g))) begin
                cond_q[g] <= PG_STALE;
            end
        end

        assign free_vec[g]                 = (cond_q[g] == PG_FREE);
        assign cnt_flat[g*CNT_W +: CNT_W]  = cnt_q[g];
    end

endmodule

// File: rtl/ftl_alloc_scan.sv
module ftl_alloc_scan #(
    parameter int PHYS_N = 32,
    parameter int CNT_W  = 8,
    localparam int PHYS_W = $clog2(PHYS_N)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [PHYS_N-1:0]       free_vec,
    input  logic [PHYS_N*CNT_W-1:0] cnt_flat,
    output logic                    done,
    output logic                    found,
    output logic [PHYS_W-1:0]       best_idx
);

    localparam logic [PHYS_W-1:0] LAST = PHYS_W'(PHYS_N - 1);

    logic              running_q;
    logic [PHYS_W-1:0] idx_q;
    logic [CNT_W-1:0]  best_cnt_q;
    logic [CNT_W-1:0]  cur_cnt;
    logic              take;

    assign cur_cnt = cnt_flat[idx_q*CNT_W +: CNT_W];
    assign take    = free_vec[idx_q] && (!found || (cur_cnt < best_cnt_q));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q  <= 1'b0;
            idx_q      <= '0;
            done       <= 1'b0;
            found      <= 1'b0;
            best_idx   <= '0;
            best_cnt_q <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                running_q  <= 1'b1;
                idx_q      <= '0;
                found      <= 1'b0;
                best_idx   <= '0;
                best_cnt_q <= '0;
            end else if (running_q) begin
                if (take) begin
                    found      <= 1'b1;
                    best_idx   <= idx_q;
                    best_cnt_q <= cur_cnt;
                end
                if (idx_q == LAST) begin
                    running_q <= 1'b0;
                    done      <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ftl_xlate.sv
module ftl_xlate
    import ftl_pkg::*;
#(
    parameter int LOG_N  = 16,
    parameter int PHYS_N = 32,
    parameter int CNT_W  = 8,
    localparam int LOG_W  = $clog2(LOG_N),
    localparam int PHYS_W = $clog2(PHYS_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [LOG_W-1:0]  req_lpage,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [1:0]        resp_status,
    output logic [PHYS_W-1:0] resp_ppage
);

    ctl_state_e state_q, state_d;
    logic [LOG_W-1:0]       lpage_q;
    logic                   wr_q;
    logic                   req_fire;
    logic                   old_mapped;
    logic [PHYS_W-1:0]      old_ppage;
    logic                   scan_start;
    logic                   scan_done;
    logic                   scan_found;
    logic [PHYS_W-1:0]      scan_idx;
    logic [PHYS_N-1:0]      free_vec;
    logic [PHYS_N*CNT_W-1:0] cnt_flat;
    logic                   commit_en;
    logic                   retire_en;

    assign req_ready  = (state_q == S_IDLE);
    assign req_fire   = req_ready && req_valid;
    assign scan_start = (state_q == S_DECODE) && wr_q;
    assign commit_en  = (state_q == S_COMMIT);
    assign retire_en  = commit_en && old_mapped;

    ftl_map_table #(.LOG_N(LOG_N), .PHYS_N(PHYS_N)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_lpage  (lpage_q),
        .rd_mapped (old_mapped),
        .rd_ppage  (old_ppage),
        .wr_en     (commit_en),
        .wr_lpage  (lpage_q),
        .wr_ppage  (scan_idx)
    );

    ftl_page_pool #(.PHYS_N(PHYS_N), .CNT_W(CNT_W)) u_pool (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (commit_en),
        .alloc_idx  (scan_idx),
        .retire_en  (retire_en),
        .retire_idx (old_ppage),
        .free_vec   (free_vec),
        .cnt_flat   (cnt_flat)
    );

    ftl_alloc_scan #(.PHYS_N(PHYS_N), .CNT_W(CNT_W)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (scan_start),
        .free_vec (free_vec),
        .cnt_flat (cnt_flat),
        .done     (scan_done),
        .found    (scan_found),
        .best_idx (scan_idx)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (req_valid) state_d = S_DECODE;
            S_DECODE: state_d = wr_q ? S_SCAN : S_IDLE;
            S_SCAN:   if (scan_done) state_d = scan_found ? S_COMMIT : S_IDLE;
            S_COMMIT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            lpage_q <= '0;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (req_fire) begin
                lpage_q <= req_lpage;
                wr_q    <= req_write;
            end
        end
    end

    // Response outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_status <= XS_OK;
            resp_ppage  <= '0;
        end else begin
            resp_valid <= 1'b0;
            unique case (state_q)
                S_DECODE: begin
                    if (!wr_q) begin
                        resp_valid  <= 1'b1;
                        resp_status <= old_mapped ? XS_OK : XS_UNMAPPED;
                        resp_ppage  <= old_mapped ? old_ppage : '0;
                    end
                end
                S_SCAN: begin
                    if (scan_done && !scan_found) begin
                        resp_valid  <= 1'b1;
                        resp_status <= XS_FULL;
                        resp_ppage  <= '0;
                    end
                end
                S_COMMIT: begin
                    resp_valid  <= 1'b1;
                    resp_status <= XS_OK;
                    resp_ppage  <= scan_idx;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ftl_xlate_chk.sv
module ftl_xlate_chk #(
    parameter int PHYS_N = 32,
    localparam int PHYS_W = $clog2(PHYS_N)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic [1:0]        resp_status,
    input logic [PHYS_W-1:0] resp_ppage,
    input logic              scan_done,
    input logic              scan_found,
    input logic [PHYS_W-1:0] scan_idx,
    input logic [PHYS_N-1:0] free_vec,
    input logic              commit_en,
    input logic              old_mapped,
    input logic [PHYS_W-1:0] old_ppage
);

    // R9
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R7
    err_page_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && (resp_status != 2'b00)) |-> (resp_ppage == '0));

    // R5
    pick_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_done && scan_found) |-> free_vec[scan_idx]);

    // R7
    none_means_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_done && !scan_found) |-> (free_vec == '0));

    // R4
    out_of_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && old_mapped) |-> (scan_idx != old_ppage));

    // R6
    free_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> ($countones(free_vec) <= $past($countones(free_vec))));

endmodule

bind ftl_xlate ftl_xlate_chk #(.PHYS_N(PHYS_N)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .resp_valid  (resp_valid),
    .resp_status (resp_status),
    .resp_ppage  (resp_ppage),
    .scan_done   (scan_done),
    .scan_found  (scan_found),
    .scan_idx    (scan_idx),
    .free_vec    (free_vec),
    .commit_en   (commit_en),
    .old_mapped  (old_mapped),
    .old_ppage   (old_ppage)
);

// File: tb/tb_ftl_xlate.sv
module tb_ftl_xlate;

    localparam int LN = 16;
    localparam int PN = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [3:0] req_lpage = '0;
    logic       req_ready;
    logic       resp_valid;
    logic [1:0] resp_status;
    logic [4:0] resp_ppage;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // model
    bit m_mapped [LN];
    int m_target [LN];
    int m_cond   [PN];   // 0 free, 1 valid, 2 stale
    int m_cnt    [PN];

    always #10 clk = ~clk;

    ftl_xlate dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_lpage(req_lpage), .req_ready(req_ready), .resp_valid(resp_valid),
        .resp_status(resp_status), .resp_ppage(resp_ppage)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_pick();
        int best = -1;
        for (int i = 0; i < PN; i++) begin
            if (m_cond[i] == 0 && (best < 0 || m_cnt[i] < m_cnt[best])) best = i;
        end
        return best;
    endfunction

    task automatic wait_resp(output int cycles);
        cycles = 0;
        while (!resp_valid && cycles < 100) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic do_read(input int lp);
        int cyc;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_lpage = 4'(lp);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R8 ready low after read accept", int'(req_ready), 0);
        chk(resp_valid == 1'b0, "R3 read not early", int'(resp_valid), 0);
        @(negedge clk);
        chk(resp_valid == 1'b1, "R3 read latency", int'(resp_valid), 1);
        wait_resp(cyc);
        if (m_mapped[lp]) begin
            chk(resp_status == 2'b00, "R3 read status", int'(resp_status), 0);
            chk(int'(resp_ppage) == m_target[lp], "R3 read page", int'(resp_ppage), m_target[lp]);
        end else begin
            chk(resp_status == 2'b01, "R2 unmapped status", int'(resp_status), 1);
            chk(resp_ppage == 5'd0, "R2 unmapped page", int'(resp_ppage), 0);
        end
        @(negedge clk);
        chk(resp_valid == 1'b0, "R9 single pulse", int'(resp_valid), 0);
    endtask

    task automatic do_write(input int lp, input bit poke_busy = 1'b0, input int poke_lp = 0);
        int cyc;
        int exp;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_lpage = 4'(lp);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R8 ready low after write accept", int'(req_ready), 0);
        if (poke_busy) begin
            repeat (3) @(negedge clk);
            req_valid = 1'b1; req_write = 1'b1; req_lpage = 4'(poke_lp);
            @(negedge clk);
            req_valid = 1'b0;
            chk(req_ready == 1'b0, "R8 still busy", int'(req_ready), 0);
        end
        wait_resp(cyc);
        exp = model_pick();
        if (exp < 0) begin
            chk(resp_status == 2'b10, "R7 full status", int'(resp_status), 2);
            chk(resp_ppage == 5'd0, "R7 full page", int'(resp_ppage), 0);
        end else begin
            chk(resp_status == 2'b00, "R4 write status", int'(resp_status), 0);
            chk(int'(resp_ppage) == exp, "R5 allocation choice", int'(resp_ppage), exp);
            chk(m_cond[resp_ppage] == 0, "R6 page not reused", m_cond[resp_ppage], 0);
            if (m_mapped[lp]) begin
                chk(int'(resp_ppage) != m_target[lp], "R4 out of place", int'(resp_ppage), m_target[lp]);
                m_cond[m_target[lp]] = 2;
            end
            m_cond[exp] = 1;
            m_cnt[exp]++;
            m_mapped[lp] = 1'b1;
            m_target[lp] = exp;
        end
        @(negedge clk);
        chk(resp_valid == 1'b0, "R9 single pulse", int'(resp_valid), 0);
    endtask

    task automatic t_reset();
        for (int i = 0; i < LN; i++) begin m_mapped[i] = 1'b0; m_target[i] = 0; end
        for (int i = 0; i < PN; i++) begin m_cond[i] = 0; m_cnt[i] = 0; end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(resp_valid == 1'b0, "R1 no response after reset", int'(resp_valid), 0);
    endtask

    task automatic t_unmapped_all();
        for (int i = 0; i < LN; i++) do_read(i);   // R1, R2
    endtask

    task automatic t_rewrite_same();
        do_write(3);          // R5: page 0
        do_read(3);           // R3
        do_write(3);          // R4: page 1
        do_read(3);
        do_read(4);           // R3 other page untouched
    endtask

    task automatic t_busy_ignore();
        int extra = 0;
        do_write(9, 1'b1, 10);
        repeat (40) begin
            @(negedge clk);
            if (resp_valid) extra++;
        end
        chk(extra == 0, "R8 busy request ignored (no response)", extra, 0);
        do_read(10);          // R8: still unmapped
        do_read(9);
    endtask

    task automatic t_fill_and_full();
        for (int k = 0; k < 29; k++) do_write(k % LN);   // R5, R6
        do_write(5);          // R7 full
        for (int i = 0; i < LN; i++) do_read(i);         // R7 map unchanged
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_unmapped_all();
        t_rewrite_same();
        t_busy_ignore();
        t_fill_and_full();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule